// File: doc/BRIEF.md
# Framed Serial Register-Write Master

This block writes configuration registers of an external display controller over a three-wire, bit-serial link. The wires are a serial clock, a data output and an active-low chip select. Every transfer on the wire is a 24-bit frame. It begins with a start byte that says what the payload is. The start byte is followed by a 16-bit payload.

A register write on the wire takes two frames. The first frame names the register and the second frame carries the value to store. A caller can also ask for the index frame alone. This leaves the controller pointing at a register, for example before a stream of data that some other path sends.

The user side is a simple valid/ready handshake. A request carries a flag that picks between a full write and an index-only transfer, an 8-bit register index and a 16-bit value. All wire timing is derived from system-clock counts that are set by parameters:

- the length of one clock phase,
- the chip-select setup time,
- the idle gap after each bit,
- the idle spacing around chip select.

One shared down-counter measures every interval.

Top module: `serial_regwr_master`

## Requirements
- R1: A frame is 24 bits: the start byte, then payload bits 15..8, then payload bits 7..0, each byte most significant bit first.
- R2: The start byte is 8'h70 for an index frame and 8'h72 for a value frame.
- R3: A request with `req_full`=1 produces an index frame followed by a value frame. A request with `req_full`=0 produces only the index frame.
- R4: The index frame payload is the 8-bit index zero-extended to 16 bits, so payload bits 15..8 are zero.
- R5: Before chip select falls, clock and data have both been high with chip select high for at least IDLE_CLKS cycles. After chip select falls, the first clock fall comes exactly SETUP_CLKS cycles later.
- R6: Each bit works as follows:
  - Clock is low for UNIT_CLKS cycles with the data bit driven.
  - Clock is then high for UNIT_CLKS cycles with the data unchanged across the rising edge.
  - Clock and data are then both high for GAP_CLKS cycles.
- R7: After the gap of the 24th bit, chip select rises at once, with clock and data high.
- R8: `req_ready` falls in the cycle after a request is accepted. It stays low until the last frame has ended, and rises IDLE_CLKS cycles after the final chip-select rise. No request is taken while it is low.
- R9: While reset is applied and after it, chip select, clock, data and `req_ready` are all high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_full | input | 1 | 1: index frame then value frame; 0: index frame only |
| req_index | input | IDX_W | Register index |
| req_data | input | PAY_W | Register value |
| req_ready | output | 1 | Block idle; a request is accepted when this and req_valid are both high at a clock edge |
| ser_cs_n | output | 1 | Chip select, active low |
| ser_clk | output | 1 | Serial clock; the receiver samples on its rising edge |
| ser_dout | output | 1 | Serial data |

## Verification
Take the edge that accepts a request as cycle k:

- `req_ready` is low from k+1.
- Chip select falls at k+IDLE_CLKS.
- The first clock fall comes SETUP_CLKS cycles after the chip-select fall.
- Each later edge is a fixed count after the previous one: UNIT_CLKS from fall to rise, and UNIT_CLKS+GAP_CLKS from rise to the next fall or to the chip-select rise.
- `req_ready` returns IDLE_CLKS cycles after the final chip-select rise.

The monitor samples on the falling system-clock edge and counts the run length of every level. It compares each run with these constants at the moment the level changes, so a single cycle of drift is reported.

Frames are rebuilt from the data seen at each clock rise. They are checked against a queue that the driver fills before it raises the request.

// File: rtl/srw_pkg.sv
package srw_pkg;

    localparam logic [7:0] START_INDEX = 8'h70;
    localparam logic [7:0] START_VALUE = 8'h72;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_PRE   = 3'd1,
        PH_SETUP = 3'd2,
        PH_LOW   = 3'd3,
        PH_HIGH  = 3'd4,
        PH_GAP   = 3'd5,
        PH_POST  = 3'd6
    } phase_t;

endpackage

// File: rtl/srw_frame_pack.sv
module srw_frame_pack #(
    parameter int PAY_W   = 16,
    localparam int FRAME_W = 8 + PAY_W
) (
    input  logic [7:0]         start_code,
    input  logic [PAY_W-1:0]   payload,
    output logic [FRAME_W-1:0] frame
);
    // start byte leads; payload follows with its top bit first
    assign frame = {start_code, payload};
endmodule

// File: rtl/srw_tick_timer.sv
module srw_tick_timer #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/serial_regwr_master.sv
module serial_regwr_master
    import srw_pkg::*;
#(
    parameter int UNIT_CLKS  = 4,
    parameter int SETUP_CLKS = 40,
    parameter int GAP_CLKS   = 12,
    parameter int IDLE_CLKS  = 4,
    parameter int IDX_W      = 8,
    parameter int PAY_W      = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_full,
    input  logic [IDX_W-1:0] req_index,
    input  logic [PAY_W-1:0] req_data,
    output logic             req_ready,
    output logic             ser_cs_n,
    output logic             ser_clk,
    output logic             ser_dout
);
    localparam int FRAME_W = 8 + PAY_W;
    localparam int BIT_W   = $clog2(FRAME_W);
    localparam int MAX_A   = (UNIT_CLKS > GAP_CLKS) ? UNIT_CLKS : GAP_CLKS;
    localparam int MAX_B   = (SETUP_CLKS > IDLE_CLKS) ? SETUP_CLKS : IDLE_CLKS;
    localparam int MAX_CLK = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_CLK + 1);
    localparam int NFRAMES = 2;

    localparam logic [CNT_W-1:0] LD_UNIT  = CNT_W'(UNIT_CLKS - 1);
    localparam logic [CNT_W-1:0] LD_SETUP = CNT_W'(SETUP_CLKS - 1);
    localparam logic [CNT_W-1:0] LD_GAP   = CNT_W'(GAP_CLKS - 1);
    localparam logic [CNT_W-1:0] LD_IDLE  = CNT_W'(IDLE_CLKS - 1);

    typedef struct packed {
        phase_t             phase;
        logic [FRAME_W-1:0] shreg;
        logic [FRAME_W-1:0] held;
        logic               pend;
        logic [BIT_W-1:0]   bits_left;
        logic               cs_n;
        logic               sclk;
        logic               sdo;
        logic               ready;
    } st_t;

    st_t st_d, st_q;

    // frame assembly: slot 0 is the index frame, slot 1 the value frame
    logic [7:0]         code  [NFRAMES];
    logic [PAY_W-1:0]   pay   [NFRAMES];
    logic [FRAME_W-1:0] frame [NFRAMES];

    for (genvar g = 0; g < NFRAMES; g++) begin : g_frame
        if (g == 0) begin : g_idx
            assign code[g] = START_INDEX;
            assign pay[g]  = {{(PAY_W-IDX_W){1'b0}}, req_index};
        end else begin : g_val
            assign code[g] = START_VALUE;
            assign pay[g]  = req_data;
        end
        srw_frame_pack #(.PAY_W(PAY_W)) u_pack (
            .start_code (code[g]),
            .payload    (pay[g]),
            .frame      (frame[g])
        );
    end

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;

    srw_tick_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    always_comb begin
        st_d     = st_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (req_valid) begin
                    st_d.phase = PH_PRE;
                    st_d.shreg = frame[0];
                    st_d.held  = frame[1];
                    st_d.pend  = req_full;
                    st_d.ready = 1'b0;
                    tmr_load   = 1'b1;
                    tmr_val    = LD_IDLE;
                end
            end
            PH_PRE: begin
                if (tmr_done) begin
                    st_d.phase = PH_SETUP;
                    st_d.cs_n  = 1'b0;
                    tmr_load   = 1'b1;
                    tmr_val    = LD_SETUP;
                end
            end
            PH_SETUP: begin
                if (tmr_done) begin
                    st_d.phase     = PH_LOW;
                    st_d.sclk      = 1'b0;
                    st_d.sdo       = st_q.shreg[FRAME_W-1];
                    st_d.bits_left = BIT_W'(FRAME_W - 1);
                    tmr_load       = 1'b1;
                    tmr_val        = LD_UNIT;
                end
            end
            PH_LOW: begin
                if (tmr_done) begin
                    st_d.phase = PH_HIGH;
                    st_d.sclk  = 1'b1;
                    tmr_load   = 1'b1;
                    tmr_val    = LD_UNIT;
                end
            end
            PH_HIGH: begin
                if (tmr_done) begin
                    st_d.phase = PH_GAP;
                    st_d.sdo   = 1'b1;
                    st_d.shreg = {st_q.shreg[FRAME_W-2:0], 1'b0};
                    tmr_load   = 1'b1;
                    tmr_val    = LD_GAP;
                end
            end
            PH_GAP: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    if (st_q.bits_left == '0) begin
                        st_d.phase = PH_POST;
                        st_d.cs_n  = 1'b1;
                        tmr_val    = LD_IDLE;
                    end else begin
                        st_d.phase     = PH_LOW;
                        st_d.sclk      = 1'b0;
                        st_d.sdo       = st_q.shreg[FRAME_W-1];
                        st_d.bits_left = st_q.bits_left - 1'b1;
                        tmr_val        = LD_UNIT;
                    end
                end
            end
            PH_POST: begin
                if (tmr_done) begin
                    if (st_q.pend) begin
                        st_d.phase = PH_PRE;
                        st_d.pend  = 1'b0;
                        st_d.shreg = st_q.held;
                        tmr_load   = 1'b1;
                        tmr_val    = LD_IDLE;
                    end else begin
                        st_d.phase = PH_IDLE;
                        st_d.ready = 1'b1;
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q           <= '0;
            st_q.phase     <= PH_IDLE;
            st_q.cs_n      <= 1'b1;
            st_q.sclk      <= 1'b1;
            st_q.sdo       <= 1'b1;
            st_q.ready     <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = st_q.ready;
    assign ser_cs_n  = st_q.cs_n;
    assign ser_clk   = st_q.sclk;
    assign ser_dout  = st_q.sdo;
endmodule

// File: rtl/srw_checker.sv
module srw_checker (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic ser_cs_n,
    input logic ser_clk,
    input logic ser_dout
);
    // R5: bus is all high in the cycle before chip select falls
    assert_idle_before_select_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(ser_cs_n) |-> ($past(ser_clk) && $past(ser_dout)));

    // R6: data does not move across a rising serial clock
    assert_data_held_at_rise_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(ser_clk) |-> $stable(ser_dout));

    // R7: serial clock toggles only inside a selected frame
    assert_clock_only_selected_R7: assert property (@(posedge clk) disable iff (rst)
        ser_cs_n |-> (ser_clk && ser_dout));

    // R8: no readiness while a frame is on the wire
    assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (rst)
        !ser_cs_n |-> !req_ready);

    // R8: acceptance drops ready in the next cycle
    assert_accept_drops_ready_R8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R9: reset leaves the link idle and the block ready
    assert_reset_state_R9: assert property (@(posedge clk)
        rst |=> (ser_cs_n && ser_clk && ser_dout && req_ready));
endmodule

bind serial_regwr_master srw_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .ser_cs_n  (ser_cs_n),
    .ser_clk   (ser_clk),
    .ser_dout  (ser_dout)
);

// File: tb/sim_serial_regwr_master.sv
module sim_serial_regwr_master;
    localparam int CLK_PERIOD = 10;
    localparam int UNIT  = 4;
    localparam int SETUP = 40;
    localparam int GAP   = 12;
    localparam int IDLE  = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_full = 1'b0;
    logic [7:0]  req_index = '0;
    logic [15:0] req_data = '0;
    logic        req_ready, ser_cs_n, ser_clk, ser_dout;

    int errs = 0;
    int checks = 0;
    int cyc = 0;
    int cs_rise_cyc = 0;
    logic [23:0] exp_q[$];

    serial_regwr_master #(
        .UNIT_CLKS(UNIT), .SETUP_CLKS(SETUP), .GAP_CLKS(GAP), .IDLE_CLKS(IDLE),
        .IDX_W(8), .PAY_W(16)
    ) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_full(req_full),
        .req_index(req_index), .req_data(req_data), .req_ready(req_ready),
        .ser_cs_n(ser_cs_n), .ser_clk(ser_clk), .ser_dout(ser_dout)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // monitor: run-length timing checks and frame reassembly
    logic        p_cs = 1'b1, p_clk = 1'b1, p_do = 1'b1;
    int          hi_run = 0, setup_cnt = 0, low_run = 0, high_run = 0, nbits = 0;
    bit          first_bit = 1'b0;
    logic [23:0] word = '0;

    always @(negedge clk) begin
        if (!rst) begin
            if (ser_cs_n) begin
                if (!p_cs) begin
                    chk(nbits == 24, "R1 bit count", nbits, 24);
                    chk(high_run == UNIT + GAP, "R7 last gap to deselect", high_run, UNIT + GAP);
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R3 unexpected frame", word, 0);
                    end else begin
                        logic [23:0] e;
                        e = exp_q.pop_front();
                        chk(word == e, "R1 R2 R4 frame content", word, e);
                    end
                    cs_rise_cyc = cyc;
                end
                hi_run = (ser_clk && ser_dout) ? hi_run + 1 : 0;
            end else if (p_cs) begin
                chk(hi_run >= IDLE, "R5 idle before select", hi_run, IDLE);
                setup_cnt = 1;
                first_bit = 1'b1;
                nbits = 0;
                word = '0;
                high_run = 0;
            end else if (!ser_clk) begin
                if (p_clk) begin
                    if (first_bit)
                        chk(setup_cnt == SETUP, "R5 select setup", setup_cnt, SETUP);
                    else
                        chk(high_run == UNIT + GAP, "R6 high plus gap", high_run, UNIT + GAP);
                    first_bit = 1'b0;
                    low_run = 1;
                end else begin
                    low_run++;
                end
            end else begin
                if (!p_clk) begin
                    chk(low_run == UNIT, "R6 clock low time", low_run, UNIT);
                    chk(ser_dout == p_do, "R6 data held at rise", ser_dout, p_do);
                    word = {word[22:0], ser_dout};
                    nbits++;
                    high_run = 1;
                end else if (first_bit) begin
                    setup_cnt++;
                end else begin
                    high_run++;
                    if (high_run == UNIT + 1)
                        chk(ser_dout == 1'b1, "R6 data high in gap", ser_dout, 1);
                end
            end
            p_cs  = ser_cs_n;
            p_clk = ser_clk;
            p_do  = ser_dout;
        end
    end

    // driver: push expected frames, then perform the handshake
    task automatic send(input bit full, input logic [7:0] idx, input logic [15:0] val);
        bit waited = 1'b0;
        exp_q.push_back({8'h70, 8'h00, idx});
        if (full) exp_q.push_back({8'h72, val});
        @(negedge clk);
        req_valid = 1'b1;
        req_full  = full;
        req_index = idx;
        req_data  = val;
        while (!req_ready) begin
            waited = 1'b1;
            @(negedge clk);
        end
        if (waited)
            chk(cyc - cs_rise_cyc == IDLE, "R8 ready after final deselect", cyc - cs_rise_cyc, IDLE);
        chk(ser_cs_n == 1'b1, "R8 accepted only while idle", ser_cs_n, 1);
        @(negedge clk);
        req_valid = 1'b0;
        req_index = 8'hEE;
        req_data  = 16'hDEAD;
        chk(req_ready == 1'b0, "R8 ready low after accept", req_ready, 0);
    endtask

    task automatic finish_wait();
        while (!req_ready) @(negedge clk);
        chk(cyc - cs_rise_cyc == IDLE, "R8 ready after final deselect", cyc - cs_rise_cyc, IDLE);
        chk(exp_q.size() == 0, "R3 all frames delivered", exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({ser_cs_n, ser_clk, ser_dout, req_ready} == 4'hF, "R9 outputs in reset",
            {ser_cs_n, ser_clk, ser_dout, req_ready}, 4'hF);
        rst = 1'b0;
        repeat (6) @(negedge clk);
        chk({ser_cs_n, ser_clk, ser_dout, req_ready} == 4'hF, "R9 idle after reset",
            {ser_cs_n, ser_clk, ser_dout, req_ready}, 4'hF);

        send(1'b1, 8'h03, 16'h4444);  finish_wait();   // R3 full write
        send(1'b0, 8'h22, 16'hBEEF);  finish_wait();   // R3 index only, data ignored
        send(1'b1, 8'hFF, 16'h0000);  finish_wait();   // R4 high index bits stay zero
        send(1'b1, 8'h00, 16'hFFFF);  finish_wait();   // R1 all-ones payload
        send(1'b1, 8'hA5, 16'h5A3C);  finish_wait();   // R1 mixed pattern
        // R8 second request waits while the first is on the wire
        send(1'b0, 8'h10, 16'h0000);
        send(1'b1, 8'h11, 16'h1234);
        finish_wait();

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule